// File: doc/BRIEF.md
# Memory-mapped / streaming bridging FIFO

This block is a single-clock first-in first-out buffer. Each of its two sides is chosen when the block is built. The write side is either a memory-mapped write agent or a streaming sink. The read side is either a memory-mapped read agent or a streaming source. Entries leave in the order they arrived. A streaming sink packs each beat's symbols into power-of-two slots of a 32-bit storage word. A streaming source unpacks them again. Channel, error and packet-boundary bits travel in the same entry as the data.

A parameter turns flow control on or off. With it on, a memory-mapped host is stalled through its waitrequest while the buffer cannot serve it. Streaming peers see ready and valid. With it off, the buffer never stalls anyone. A write into a full buffer is lost, and a read from an empty buffer returns zero.

Occupancy is tracked by a small state machine with three states. FILL_EMPTY holds no entries. FILL_PARTIAL holds between one and DEPTH-1 entries. FILL_FULL holds DEPTH entries. The transitions are:
- EMPTY to PARTIAL on any accepted write.
- PARTIAL to FULL when a write alone takes the last free slot.
- PARTIAL to EMPTY when a read alone takes the last entry.
- FULL to PARTIAL on an accepted read.

The state stays where it is when a write and a read are accepted in the same cycle.

Top module: `bridge_fifo`

## Requirements
- R1: WR_STREAM selects the write side: 1 gives a streaming sink, 0 gives a memory-mapped write agent. RD_STREAM selects the read side in the same way. Accepted entries leave in the order they were accepted.
- R2: With BACKPRESSURE=1 and a memory-mapped write side, mmw_waitrequest is high exactly while DEPTH entries are held. A write held under waitrequest is taken once a read frees a slot.
- R3: With BACKPRESSURE=1 and a memory-mapped read side, mmr_waitrequest is high while the buffer is empty. An accepted read returns the oldest entry on mmr_readdata in the same cycle.
- R4: With BACKPRESSURE=1, snk_ready is low while the buffer is full and src_valid is high while it is not empty. While src_valid is high and src_ready is low, the source data and sideband outputs hold steady.
- R5: When both sides are memory-mapped, the stored word is MM_W bits wide (8, 16 or 32). If either side is streaming, the stored word is 32 bits.
- R6: Symbol i of snk_data, at bits [i*SYM_BITS +: SYM_BITS], is stored zero-padded in bits [i*SLOT_W +: SLOT_W] of the word. SLOT_W is the smallest power of two not below SYM_BITS, and bits above the last slot are zero. For example, 10-bit symbols use 16-bit slots, so at most two fit a beat. SYMS_PER_BEAT*SLOT_W must not exceed 32.
- R7: With PACKETS=1, snk_sop and snk_eop are stored with each entry and reproduced on src_sop and src_eop. With PACKETS=0, both outputs read 0.
- R8: snk_channel and snk_error are stored with the entry and presented unchanged on src_channel and src_error. They are stored as zero when the write side is memory-mapped.
- R9: The fill count rises by one on a write alone and falls by one on a read alone. It is unchanged when both are accepted in one cycle. FILL_FULL holds exactly when the count equals DEPTH, and FILL_EMPTY exactly when it is zero.
- R10: With BACKPRESSURE=0, a write into a full buffer is discarded. snk_ready stays 1 and mmw_waitrequest stays 0.
- R11: With BACKPRESSURE=0, a memory-mapped read of an empty buffer returns zero and moves no pointer, and mmr_waitrequest stays 0.
- R12: After reset the buffer is empty. src_valid is 0, mmw_waitrequest is 0, and with BACKPRESSURE=1 snk_ready is 1 and mmr_waitrequest is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mmw_write | input | 1 | Memory-mapped write strobe |
| mmw_writedata | input | MM_W | Memory-mapped write data |
| mmw_waitrequest | output | 1 | Write stall (full) |
| snk_valid | input | 1 | Sink beat valid |
| snk_ready | output | 1 | Sink can accept |
| snk_data | input | SYM_BITS*SYMS_PER_BEAT | Sink symbols, symbol 0 lowest |
| snk_channel | input | CHAN_W | Sink channel |
| snk_error | input | ERR_W | Sink error bits |
| snk_sop | input | 1 | Sink start of packet |
| snk_eop | input | 1 | Sink end of packet |
| mmr_read | input | 1 | Memory-mapped read strobe |
| mmr_readdata | output | MM_W | Memory-mapped read data |
| mmr_waitrequest | output | 1 | Read stall (empty) |
| src_valid | output | 1 | Source beat valid |
| src_ready | input | 1 | Source consumer ready |
| src_data | output | SYM_BITS*SYMS_PER_BEAT | Source symbols |
| src_channel | output | CHAN_W | Source channel |
| src_error | output | ERR_W | Source error bits |
| src_sop | output | 1 | Source start of packet |
| src_eop | output | 1 | Source end of packet |

## Verification
A write or sink beat is taken at the rising edge that ends the cycle in which it was offered. The entry shows on the source one cycle later, and full, snk_ready and mmw_waitrequest change in that same cycle. A memory-mapped read returns its data in the very cycle it is accepted. The bench drives inputs one nanosecond after each rising edge and samples at the falling edge. A driver therefore knows at the falling edge whether its offer will be taken, and pushes the expected entry into a scoreboard queue. The monitor pops the queue at the falling edge of the cycle in which the result is due.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;

    // smallest power of two that is not below bits
    function automatic int slot_width(input int bits);
        int w;
        w = 1;
        for (int i = 0; i < 32; i++) begin
            if (w < bits) w = w * 2;
        end
        return w;
    endfunction

endpackage

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
    import bfifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr
);

    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    fill_state_e   state, state_nxt;
    logic [CW-1:0] count, count_nxt;

    always_comb begin
        count_nxt = count;
        if (push_ok && !pop_ok) begin
            count_nxt = count + 1'b1;
        end else if (pop_ok && !push_ok) begin
            count_nxt = count - 1'b1;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            FILL_EMPTY: begin
                if (push_ok) state_nxt = FILL_PARTIAL;
            end
            FILL_PARTIAL: begin
                if (count_nxt == '0) begin
                    state_nxt = FILL_EMPTY;
                end else if (count_nxt == DEPTH_C) begin
                    state_nxt = FILL_FULL;
                end
            end
            FILL_FULL: begin
                if (pop_ok) state_nxt = FILL_PARTIAL;
            end
            default: state_nxt = FILL_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= FILL_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            state <= state_nxt;
            count <= count_nxt;
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_comb begin
        full    = (state == FILL_FULL);
        empty   = (state == FILL_EMPTY);
        push_ok = push_req && !full;
        pop_ok  = pop_req && !empty;
    end

    // R9
    count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

    // R9
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && !push_ok) |=> (count == $past(count) - 1'b1));

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(count));

    // R9
    state_fill_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FILL_FULL) == (count == DEPTH_C)) &&
        ((state == FILL_EMPTY) == (count == '0)));

endmodule

// File: rtl/bfifo_store.sv
module bfifo_store #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bfifo_wr_port.sv
module bfifo_wr_port #(
    parameter bit WR_STREAM    = 1'b1,
    parameter bit BACKPRESSURE = 1'b1,
    parameter bit PACKETS      = 1'b1,
    parameter int MM_W         = 32,
    parameter int SYM_BITS     = 10,
    parameter int SYMS         = 2,
    parameter int SLOT_W       = 16,
    parameter int CHAN_W       = 2,
    parameter int ERR_W        = 1,
    parameter int WORD_W       = 32
) (
    input  logic                     full,
    input  logic                     mmw_write,
    input  logic [MM_W-1:0]          mmw_writedata,
    output logic                     mmw_waitrequest,
    input  logic                     snk_valid,
    output logic                     snk_ready,
    input  logic [SYM_BITS*SYMS-1:0] snk_data,
    input  logic [CHAN_W-1:0]        snk_channel,
    input  logic [ERR_W-1:0]         snk_error,
    input  logic                     snk_sop,
    input  logic                     snk_eop,
    output logic                     push_req,
    output logic [WORD_W-1:0]        word,
    output logic [CHAN_W-1:0]        chan,
    output logic [ERR_W-1:0]         err,
    output logic                     sop,
    output logic                     eop
);

    if (WR_STREAM) begin : g_st
        for (genvar i = 0; i < SYMS; i++) begin : g_slot
            assign word[i*SLOT_W +: SLOT_W] = SLOT_W'(snk_data[i*SYM_BITS +: SYM_BITS]);
        end
        if (WORD_W > SYMS * SLOT_W) begin : g_pad
            assign word[WORD_W-1:SYMS*SLOT_W] = '0;
        end
        assign push_req        = snk_valid;
        assign snk_ready       = BACKPRESSURE ? !full : 1'b1;
        assign mmw_waitrequest = 1'b0;
        assign chan            = snk_channel;
        assign err             = snk_error;
        assign sop             = PACKETS ? snk_sop : 1'b0;
        assign eop             = PACKETS ? snk_eop : 1'b0;
        logic unused_mm;
        assign unused_mm = ^{mmw_write, mmw_writedata};
    end else begin : g_mm
        assign word            = WORD_W'(mmw_writedata);
        assign push_req        = mmw_write;
        assign mmw_waitrequest = BACKPRESSURE ? full : 1'b0;
        assign snk_ready       = 1'b0;
        assign chan            = '0;
        assign err             = '0;
        assign sop             = 1'b0;
        assign eop             = 1'b0;
        logic unused_st;
        assign unused_st = ^{snk_valid, snk_data, snk_channel, snk_error, snk_sop, snk_eop};
    end

endmodule

// File: rtl/bfifo_rd_port.sv
module bfifo_rd_port #(
    parameter bit RD_STREAM    = 1'b1,
    parameter bit BACKPRESSURE = 1'b1,
    parameter bit PACKETS      = 1'b1,
    parameter int MM_W         = 32,
    parameter int SYM_BITS     = 10,
    parameter int SYMS         = 2,
    parameter int SLOT_W       = 16,
    parameter int CHAN_W       = 2,
    parameter int ERR_W        = 1,
    parameter int WORD_W       = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     empty,
    input  logic                     pop_ok,
    input  logic [WORD_W-1:0]        word,
    input  logic [CHAN_W-1:0]        chan,
    input  logic [ERR_W-1:0]         err,
    input  logic                     sop,
    input  logic                     eop,
    output logic                     pop_req,
    input  logic                     mmr_read,
    output logic [MM_W-1:0]          mmr_readdata,
    output logic                     mmr_waitrequest,
    output logic                     src_valid,
    input  logic                     src_ready,
    output logic [SYM_BITS*SYMS-1:0] src_data,
    output logic [CHAN_W-1:0]        src_channel,
    output logic [ERR_W-1:0]         src_error,
    output logic                     src_sop,
    output logic                     src_eop
);

    if (RD_STREAM) begin : g_st
        for (genvar i = 0; i < SYMS; i++) begin : g_slot
            assign src_data[i*SYM_BITS +: SYM_BITS] =
                empty ? '0 : word[i*SLOT_W +: SYM_BITS];
        end
        assign src_valid       = !empty;
        assign pop_req         = !empty && (BACKPRESSURE ? src_ready : 1'b1);
        assign src_channel     = empty ? '0 : chan;
        assign src_error       = empty ? '0 : err;
        assign src_sop         = PACKETS && !empty && sop;
        assign src_eop         = PACKETS && !empty && eop;
        assign mmr_readdata    = '0;
        assign mmr_waitrequest = 1'b0;
        logic unused_rd;
        assign unused_rd = ^{mmr_read, pop_ok, word};

        if (BACKPRESSURE) begin : g_hold
            // R4
            src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (src_valid && !src_ready) |=> (src_valid && $stable(src_data) &&
                    $stable(src_channel) && $stable(src_error) &&
                    $stable(src_sop) && $stable(src_eop)));
        end
    end else begin : g_mm
        assign pop_req         = mmr_read;
        assign mmr_waitrequest = BACKPRESSURE ? empty : 1'b0;
        assign mmr_readdata    = pop_ok ? MM_W'(word) : '0;
        assign src_valid       = 1'b0;
        assign src_data        = '0;
        assign src_channel     = '0;
        assign src_error       = '0;
        assign src_sop         = 1'b0;
        assign src_eop         = 1'b0;
        logic unused_rd;
        assign unused_rd = ^{src_ready, chan, err, sop, eop, word};

        // R11
        empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mmr_read && empty) |-> (mmr_readdata == '0));
    end

endmodule

// File: rtl/bridge_fifo.sv
module bridge_fifo
    import bfifo_pkg::*;
#(
    parameter bit WR_STREAM     = 1'b1,
    parameter bit RD_STREAM     = 1'b1,
    parameter bit BACKPRESSURE  = 1'b1,
    parameter bit PACKETS       = 1'b1,
    parameter int DEPTH         = 16,
    parameter int MM_W          = 32,
    parameter int SYM_BITS      = 10,
    parameter int SYMS_PER_BEAT = 2,
    parameter int CHAN_W        = 2,
    parameter int ERR_W         = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mmw_write,
    input  logic [MM_W-1:0]                   mmw_writedata,
    output logic                              mmw_waitrequest,
    input  logic                              snk_valid,
    output logic                              snk_ready,
    input  logic [SYM_BITS*SYMS_PER_BEAT-1:0] snk_data,
    input  logic [CHAN_W-1:0]                 snk_channel,
    input  logic [ERR_W-1:0]                  snk_error,
    input  logic                              snk_sop,
    input  logic                              snk_eop,
    input  logic                              mmr_read,
    output logic [MM_W-1:0]                   mmr_readdata,
    output logic                              mmr_waitrequest,
    output logic                              src_valid,
    input  logic                              src_ready,
    output logic [SYM_BITS*SYMS_PER_BEAT-1:0] src_data,
    output logic [CHAN_W-1:0]                 src_channel,
    output logic [ERR_W-1:0]                  src_error,
    output logic                              src_sop,
    output logic                              src_eop
);

    localparam int AW      = $clog2(DEPTH);
    localparam int WORD_W  = (WR_STREAM || RD_STREAM) ? 32 : MM_W;
    localparam int SLOT_W  = slot_width(SYM_BITS);
    localparam int ENTRY_W = WORD_W + CHAN_W + ERR_W + 2;

    logic              push_req, pop_req, push_ok, pop_ok, full, empty;
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [WORD_W-1:0] in_word, out_word;
    logic [CHAN_W-1:0] in_chan, out_chan;
    logic [ERR_W-1:0]  in_err, out_err;
    logic              in_sop, in_eop, out_sop, out_eop;
    logic [ENTRY_W-1:0] in_entry, out_entry;

    bfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .full     (full),
        .empty    (empty),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr)
    );

    bfifo_wr_port #(
        .WR_STREAM (WR_STREAM), .BACKPRESSURE (BACKPRESSURE), .PACKETS (PACKETS),
        .MM_W (MM_W), .SYM_BITS (SYM_BITS), .SYMS (SYMS_PER_BEAT),
        .SLOT_W (SLOT_W), .CHAN_W (CHAN_W), .ERR_W (ERR_W), .WORD_W (WORD_W)
    ) u_wr (
        .full            (full),
        .mmw_write       (mmw_write),
        .mmw_writedata   (mmw_writedata),
        .mmw_waitrequest (mmw_waitrequest),
        .snk_valid       (snk_valid),
        .snk_ready       (snk_ready),
        .snk_data        (snk_data),
        .snk_channel     (snk_channel),
        .snk_error       (snk_error),
        .snk_sop         (snk_sop),
        .snk_eop         (snk_eop),
        .push_req        (push_req),
        .word            (in_word),
        .chan            (in_chan),
        .err             (in_err),
        .sop             (in_sop),
        .eop             (in_eop)
    );

    assign in_entry = {in_sop, in_eop, in_err, in_chan, in_word};

    bfifo_store #(.W(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr),
        .wdata (in_entry),
        .raddr (rd_ptr),
        .rdata (out_entry)
    );

    assign {out_sop, out_eop, out_err, out_chan, out_word} = out_entry;

    bfifo_rd_port #(
        .RD_STREAM (RD_STREAM), .BACKPRESSURE (BACKPRESSURE), .PACKETS (PACKETS),
        .MM_W (MM_W), .SYM_BITS (SYM_BITS), .SYMS (SYMS_PER_BEAT),
        .SLOT_W (SLOT_W), .CHAN_W (CHAN_W), .ERR_W (ERR_W), .WORD_W (WORD_W)
    ) u_rd (
        .clk             (clk),
        .rst_n           (rst_n),
        .empty           (empty),
        .pop_ok          (pop_ok),
        .word            (out_word),
        .chan            (out_chan),
        .err             (out_err),
        .sop             (out_sop),
        .eop             (out_eop),
        .pop_req         (pop_req),
        .mmr_read        (mmr_read),
        .mmr_readdata    (mmr_readdata),
        .mmr_waitrequest (mmr_waitrequest),
        .src_valid       (src_valid),
        .src_ready       (src_ready),
        .src_data        (src_data),
        .src_channel     (src_channel),
        .src_error       (src_error),
        .src_sop         (src_sop),
        .src_eop         (src_eop)
    );

endmodule

// File: tb/bridge_fifo_bench.sv
`timescale 1ns/1ps
module bridge_fifo_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- instance A: stream -> stream, flow control, packets
    logic        a_snk_valid = 0, a_snk_sop = 0, a_snk_eop = 0, a_src_ready = 0;
    logic [19:0] a_snk_data = '0;
    logic [1:0]  a_snk_channel = '0;
    logic [0:0]  a_snk_error = '0;
    logic        a_snk_ready, a_src_valid, a_src_sop, a_src_eop, a_mmw_wr, a_mmr_wr;
    logic [19:0] a_src_data;
    logic [1:0]  a_src_channel;
    logic [0:0]  a_src_error;
    logic [31:0] a_mmr_readdata;
    logic [24:0] q_a [$];

    bridge_fifo #(.WR_STREAM(1), .RD_STREAM(1), .BACKPRESSURE(1), .PACKETS(1),
                  .DEPTH(4), .MM_W(32), .SYM_BITS(10), .SYMS_PER_BEAT(2),
                  .CHAN_W(2), .ERR_W(1)) u_bridge_fifo (
        .clk(clk), .rst_n(rst_n),
        .mmw_write(1'b0), .mmw_writedata(32'h0), .mmw_waitrequest(a_mmw_wr),
        .snk_valid(a_snk_valid), .snk_ready(a_snk_ready), .snk_data(a_snk_data),
        .snk_channel(a_snk_channel), .snk_error(a_snk_error),
        .snk_sop(a_snk_sop), .snk_eop(a_snk_eop),
        .mmr_read(1'b0), .mmr_readdata(a_mmr_readdata), .mmr_waitrequest(a_mmr_wr),
        .src_valid(a_src_valid), .src_ready(a_src_ready), .src_data(a_src_data),
        .src_channel(a_src_channel), .src_error(a_src_error),
        .src_sop(a_src_sop), .src_eop(a_src_eop)
    );

    // ---------------- instance B: MM -> MM, flow control, 16-bit
    logic        b_write = 0, b_read = 0;
    logic [15:0] b_writedata = '0;
    logic        b_mmw_wr, b_mmr_wr, b_snk_ready, b_src_valid, b_src_sop, b_src_eop;
    logic [15:0] b_readdata;
    logic [19:0] b_src_data;
    logic [1:0]  b_src_channel;
    logic [0:0]  b_src_error;
    logic [15:0] q_b [$];

    bridge_fifo #(.WR_STREAM(0), .RD_STREAM(0), .BACKPRESSURE(1), .PACKETS(0),
                  .DEPTH(4), .MM_W(16)) u_bridge_fifo_mm (
        .clk(clk), .rst_n(rst_n),
        .mmw_write(b_write), .mmw_writedata(b_writedata), .mmw_waitrequest(b_mmw_wr),
        .snk_valid(1'b0), .snk_ready(b_snk_ready), .snk_data(20'h0),
        .snk_channel(2'h0), .snk_error(1'b0), .snk_sop(1'b0), .snk_eop(1'b0),
        .mmr_read(b_read), .mmr_readdata(b_readdata), .mmr_waitrequest(b_mmr_wr),
        .src_valid(b_src_valid), .src_ready(1'b0), .src_data(b_src_data),
        .src_channel(b_src_channel), .src_error(b_src_error),
        .src_sop(b_src_sop), .src_eop(b_src_eop)
    );

    // ---------------- instance C: stream -> MM, no flow control
    logic        c_snk_valid = 0, c_read = 0;
    logic [19:0] c_snk_data = '0;
    logic        c_snk_ready, c_mmw_wr, c_mmr_wr, c_src_valid, c_src_sop, c_src_eop;
    logic [31:0] c_readdata;
    logic [19:0] c_src_data;
    logic [1:0]  c_src_channel;
    logic [0:0]  c_src_error;
    logic [31:0] q_c [$];

    bridge_fifo #(.WR_STREAM(1), .RD_STREAM(0), .BACKPRESSURE(0), .PACKETS(0),
                  .DEPTH(4), .MM_W(32), .SYM_BITS(10), .SYMS_PER_BEAT(2)) u_bridge_fifo_mix (
        .clk(clk), .rst_n(rst_n),
        .mmw_write(1'b0), .mmw_writedata(32'h0), .mmw_waitrequest(c_mmw_wr),
        .snk_valid(c_snk_valid), .snk_ready(c_snk_ready), .snk_data(c_snk_data),
        .snk_channel(2'h0), .snk_error(1'b0), .snk_sop(1'b0), .snk_eop(1'b0),
        .mmr_read(c_read), .mmr_readdata(c_readdata), .mmr_waitrequest(c_mmr_wr),
        .src_valid(c_src_valid), .src_ready(1'b1), .src_data(c_src_data),
        .src_channel(c_src_channel), .src_error(c_src_error),
        .src_sop(c_src_sop), .src_eop(c_src_eop)
    );

    // ---------------- A driver and monitor
    task automatic a_put(input logic [19:0] d, input logic [1:0] ch, input logic e,
                         input logic s, input logic en);
        @(posedge clk); #1;
        a_snk_valid = 1; a_snk_data = d; a_snk_channel = ch; a_snk_error = e;
        a_snk_sop = s; a_snk_eop = en;
        forever begin
            @(negedge clk);
            if (a_snk_ready) begin
                q_a.push_back({s, en, e, ch, d});
                break;
            end
        end
    endtask

    task automatic a_idle();
        @(posedge clk); #1;
        a_snk_valid = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n && a_src_valid && a_src_ready) begin
            if (q_a.size() == 0) begin
                chk("R4 beat with nothing expected", 1, 0);
            end else begin
                chk("R1/R7/R8 stream beat order, sideband",
                    {a_src_sop, a_src_eop, a_src_error, a_src_channel, a_src_data},
                    q_a.pop_front());
            end
        end
    end

    // ---------------- B driver
    task automatic b_wr(input logic [15:0] d);
        @(posedge clk); #1;
        b_write = 1; b_writedata = d;
        forever begin
            @(negedge clk);
            if (!b_mmw_wr) begin
                q_b.push_back(d);
                break;
            end
        end
        @(posedge clk); #1;
        b_write = 0;
    endtask

    task automatic b_rd();
        @(posedge clk); #1;
        b_read = 1;
        forever begin
            @(negedge clk);
            if (!b_mmr_wr) begin
                chk("R3/R5 memory-mapped read data", b_readdata, q_b.pop_front());
                break;
            end
        end
        @(posedge clk); #1;
        b_read = 0;
    endtask

    // ---------------- C driver
    task automatic c_beat(input logic [9:0] s0, input logic [9:0] s1, input bit keep);
        @(posedge clk); #1;
        c_snk_valid = 1; c_snk_data = {s1, s0};
        @(negedge clk);
        if (keep) q_c.push_back({6'b0, s1, 6'b0, s0});
    endtask

    task automatic c_rd(input string req);
        logic [31:0] e;
        @(posedge clk); #1;
        c_read = 1;
        @(negedge clk);
        e = (q_c.size() == 0) ? 32'h0 : q_c.pop_front();
        chk(req, c_readdata, e);
        @(posedge clk); #1;
        c_read = 0;
    endtask

    // ---------------- watchdog
    initial begin
        #(4 * 50000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- main sequence
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk("R12 A snk_ready", a_snk_ready, 1);
        chk("R12 A src_valid", a_src_valid, 0);
        chk("R12 B mmw_waitrequest", b_mmw_wr, 0);
        chk("R12 B mmr_waitrequest", b_mmr_wr, 1);
        chk("R10 C snk_ready", c_snk_ready, 1);
        chk("R11 C mmr_waitrequest", c_mmr_wr, 0);

        // ---- A: fill with consumer stalled
        a_put(20'h0A5F3, 2'd1, 1'b0, 1'b1, 1'b0);
        a_put(20'h12345, 2'd2, 1'b1, 1'b0, 1'b0);
        a_put(20'hFFFFF, 2'd3, 1'b0, 1'b0, 1'b0);
        a_put(20'h00001, 2'd0, 1'b1, 1'b0, 1'b1);
        a_idle();
        @(negedge clk);
        chk("R4 snk_ready low when full", a_snk_ready, 0);
        chk("R4 src_valid high when holding", a_src_valid, 1);
        fork
            a_put(20'h5A5A5, 2'd2, 1'b0, 1'b1, 1'b1);
            begin
                repeat (3) begin
                    @(negedge clk);
                    chk("R4 ready stays low while full", a_snk_ready, 0);
                    chk("R4 head held while stalled", a_src_data, 20'h0A5F3);
                end
                @(posedge clk); #1;
                a_src_ready = 1;
            end
        join
        a_idle();
        repeat (6) @(negedge clk);
        chk("R4 src_valid low once drained", a_src_valid, 0);
        chk("R1 A scoreboard drained", q_a.size(), 0);
        // back-to-back streaming with consumer ready: write and read together
        for (int i = 0; i < 8; i++) begin
            a_put(20'(i * 20'h1111 + 3), 2'(i), 1'(i), 1'(i == 0), 1'(i == 7));
        end
        a_idle();
        repeat (3) @(negedge clk);
        chk("R9 A continuous flow drained", q_a.size(), 0);
        chk("R9 A empty after flow", a_src_valid, 0);

        // ---- B: memory-mapped with waitrequest
        b_wr(16'hBEEF);
        b_wr(16'h0001);
        b_wr(16'h8000);
        b_wr(16'h7FFE);
        @(negedge clk);
        chk("R2 waitrequest when full", b_mmw_wr, 1);
        fork
            b_wr(16'hC0DE);
            begin
                repeat (3) begin
                    @(negedge clk);
                    chk("R2 write held under waitrequest", b_mmw_wr, 1);
                end
                b_rd();
            end
        join
        repeat (4) b_rd();
        @(negedge clk);
        chk("R3 waitrequest when empty", b_mmr_wr, 1);
        b_wr(16'h1234);
        @(posedge clk); #1;
        b_write = 1; b_writedata = 16'hABCD; b_read = 1;
        @(negedge clk);
        chk("R9 simultaneous read data", b_readdata, q_b.pop_front());
        chk("R9 simultaneous no stall", {b_mmw_wr, b_mmr_wr}, 2'b00);
        q_b.push_back(16'hABCD);
        @(posedge clk); #1;
        b_write = 0; b_read = 0;
        @(negedge clk);
        chk("R9 one entry after simultaneous", b_mmr_wr, 0);
        b_rd();
        @(negedge clk);
        chk("R9 empty after last read", b_mmr_wr, 1);

        // ---- C: packing, overflow drop, empty read
        c_beat(10'h3FF, 10'h155, 1'b1);
        c_beat(10'h001, 10'h200, 1'b1);
        c_beat(10'h2AA, 10'h0F0, 1'b1);
        c_beat(10'h100, 10'h3FF, 1'b1);
        c_beat(10'h0AB, 10'h0CD, 1'b0);
        chk("R10 snk_ready stays high when full", c_snk_ready, 1);
        @(posedge clk); #1;
        c_snk_valid = 0;
        @(negedge clk);
        chk("R10 mmw_waitrequest stays low", c_mmw_wr, 0);
        c_rd("R6 slot packing of beat 0");
        c_rd("R6 slot packing of beat 1");
        c_rd("R5/R6 32-bit word beat 2");
        c_rd("R10 last kept beat, drop left it intact");
        c_rd("R11 empty read returns zero");
        c_rd("R11 second empty read returns zero");
        c_beat(10'h123, 10'h321, 1'b1);
        @(posedge clk); #1;
        c_snk_valid = 0;
        c_rd("R11 pointers unmoved by empty reads");
        chk("R8 sideband zero on MM-written entries", {b_src_channel, b_src_error}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule